// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Read Rewind

This block is a first-in/first-out buffer, nine bits wide, that runs on one clock. Four active-low strobes control it: write, read, reset and retransmit. The block samples each strobe on the clock and acts on its edges, so a strobe held low for several cycles counts as one operation. Ring pointers address the storage internally, and no address comes in from outside. The extra bit beside the eight data bits can carry parity or a control mark. The block does not interpret it.

Active-low flags report three states: empty, full, and more than half full. The buffer refuses writes while it is full and reads while it is empty, and it reports each refused attempt with a one-cycle pulse. Read data is captured when the read strobe falls. A valid qualifier stays high until that strobe rises, and it takes the place of an output bus that would otherwise float. A retransmit pulse sends the read pointer back to the first location and leaves the write pointer where it is, so the data written since reset can be read out again.

Top module: `strobe_fifo`

## Requirements
- R1: While rstN is low (sampled on the clock), both pointers go to location 0. emptyN reads 0, fullN and halfN read 1, and dataValid reads 0 from the first edge of reset onwards.
- R2: Words come out of dataOut in the order they were written, with all 9 bits intact.
- R3: A falling edge of wrN while the buffer holds DEPTH words leaves the contents and the write pointer unchanged. It raises overflow for exactly one cycle.
- R4: A falling edge of rdN while the buffer is empty leaves the read pointer unchanged and leaves dataValid at 0. It raises underflow for exactly one cycle.
- R5: emptyN is 0 exactly when the read and write pointers are equal. It goes to 1 in the cycle after the first accepted write into an empty buffer.
- R6: Starting from reset with no reads, fullN goes to 0 after exactly DEPTH accepted writes. It returns to 1 after the next accepted read.
- R7: halfN goes to 0 on the accepted write that raises occupancy above DEPTH/2.
- R8: halfN returns to 1 only on the rising edge of rdN that ends a read leaving occupancy at DEPTH/2 or less. While rdN is still low it keeps its value.
- R9: A falling edge of rtN, taken while wrN and rdN are both high, sets the read pointer to 0 and leaves the write pointer alone. The flags then follow the new pointer difference.
- R10: A falling edge of rtN is ignored while wrN or rdN is low.
- R11: After rstN rises, the block stays in reset until wrN and rdN are both high. Strobes seen before then have no effect.
- R12: dataValid rises only in the cycle after an accepted read. It stays high until rdN rises.
- R13: Only the falling edge of wrN or rdN starts an operation. Holding a strobe low for several cycles moves a pointer by one place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which all strobes are sampled |
| rstN | input | 1 | Active-low reset strobe |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| rtN | input | 1 | Active-low retransmit strobe |
| dataIn | input | WIDTH | Word stored on an accepted write |
| dataOut | output | WIDTH | Word captured on the last accepted read |
| dataValid | output | 1 | dataOut is valid; high from an accepted read until rdN rises |
| emptyN | output | 1 | Low when the buffer holds no words |
| fullN | output | 1 | Low when the buffer holds DEPTH words |
| halfN | output | 1 | Low when occupancy has gone above DEPTH/2 |
| overflow | output | 1 | One-cycle pulse on a write attempt while full |
| underflow | output | 1 | One-cycle pulse on a read attempt while empty |

## Verification
The hardest condition to reach from the ports is the half-full flag during the low phase of a read. That read has already taken occupancy from DEPTH/2+1 down to DEPTH/2, so the flag must still read 0 until rdN goes high again. The stimulus fills the buffer to DEPTH and drains it one strobe at a time, sampling halfN once while rdN is low and once after it rises. A second hard case is a retransmit that moves the buffer from below half to above half, which happens without any write. To reach it, the stimulus reads a partly filled buffer down to below half and then rewinds it.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic wrEn;       // store dataIn at the write address
    logic rdEn;       // capture the word at the read address
    logic dropValid;  // read strobe released: qualifier falls
    logic clear;      // reset in force
  } memCtrl_t;

endpackage

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrN,
  input  logic          rdN,
  input  logic          rtN,
  output memCtrl_t      ctl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfN,
  output logic          overflow,
  output logic          underflow
);

  localparam int HALF = DEPTH / 2;
  localparam int NSTB = 3;

  // Strobe sampling: index 0 write, 1 read, 2 retransmit
  logic [NSTB-1:0] strobeLvl, strobePrev, strobeFall;
  assign strobeLvl = {rtN, rdN, wrN};

  always_ff @(posedge clk) strobePrev <= strobeLvl;

  for (genvar g = 0; g < NSTB; g++) begin : gFall
    assign strobeFall[g] = strobePrev[g] & ~strobeLvl[g];
  end

  logic rdRise;
  assign rdRise = ~strobePrev[1] & strobeLvl[1];

  // Reset is held until both data strobes are idle
  logic inReset, active;
  always_ff @(posedge clk) begin
    if (!rstN)                      inReset <= 1'b1;
    else if (inReset && wrN && rdN) inReset <= 1'b0;
  end
  assign active = rstN && !inReset;

  logic [PW-1:0] wPtr, rPtr, count, wPtrNext, rPtrNext, cntNext;
  logic isEmpty, isFull, wrDo, rdDo, rtDo;

  assign count   = wPtr - rPtr;
  assign isEmpty = (count == '0);
  assign isFull  = (count == PW'(DEPTH));

  assign wrDo = active && strobeFall[0] && !isFull;
  assign rdDo = active && strobeFall[1] && !isEmpty;
  assign rtDo = active && strobeFall[2] && wrN && rdN;

  assign wPtrNext = wPtr + PW'(wrDo);
  assign rPtrNext = rtDo ? '0 : rPtr + PW'(rdDo);
  assign cntNext  = wPtrNext - rPtrNext;

  always_ff @(posedge clk) begin
    if (!rstN || inReset) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      wPtr <= wPtrNext;
      rPtr <= rPtrNext;
    end
  end

  // Half-full: set by a write, cleared by the read strobe's rising edge
  logic readOpen, halfQ;
  always_ff @(posedge clk) begin
    if (!rstN || inReset) begin
      readOpen <= 1'b0;
      halfQ    <= 1'b0;
    end else begin
      if (rdDo)        readOpen <= 1'b1;
      else if (rdRise) readOpen <= 1'b0;
      if (rtDo)
        halfQ <= (cntNext > PW'(HALF));
      else if (wrDo && cntNext > PW'(HALF))
        halfQ <= 1'b1;
      else if (rdRise && readOpen && cntNext <= PW'(HALF))
        halfQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= active && strobeFall[0] && isFull;
      underflow <= active && strobeFall[1] && isEmpty;
    end
  end

  always_comb begin
    ctl.wrEn      = wrDo;
    ctl.rdEn      = rdDo;
    ctl.dropValid = rdRise;
    ctl.clear     = !rstN || inReset;
  end

  assign wrAddr = wPtr[AW-1:0];
  assign rdAddr = rPtr[AW-1:0];
  assign emptyN = !isEmpty;
  assign fullN  = !isFull;
  assign halfN  = !halfQ;

  // Checks
  assert_reset_flags_R1: assert property (@(posedge clk)
    !rstN |=> (!emptyN && fullN && halfN));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (active && strobeFall[0] && isFull) |=> (wPtr == $past(wPtr)) && overflow);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (active && strobeFall[1] && isEmpty) |=> (rPtr == $past(rPtr)) && underflow);

  assert_half_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfQ) |-> $past(wrDo || rtDo));

  assert_half_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(halfQ) && !$past(inReset)) |-> $past(rdRise || rtDo));

  assert_rewind_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtDo |=> (rPtr == '0) && (wPtr == $past(wPtr)));

endmodule

// File: rtl/strobe_fifo_data.sv
module strobe_fifo_data
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  memCtrl_t         ctl,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (ctl.rdEn) begin
      dataOut   <= store[rdAddr];
      dataValid <= 1'b1;
    end else if (ctl.dropValid) begin
      dataValid <= 1'b0;
    end
  end

  assert_valid_source_R12: assert property (@(posedge clk) disable iff (ctl.clear)
    $rose(dataValid) |-> $past(ctl.rdEn));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             rtN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid,
  output logic             emptyN,
  output logic             fullN,
  output logic             halfN,
  output logic             overflow,
  output logic             underflow
);

  localparam int AW = $clog2(DEPTH);

  memCtrl_t      ctl;
  logic [AW-1:0] wrAddr, rdAddr;

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN),
    .overflow(overflow), .underflow(underflow)
  );

  strobe_fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut), .dataValid(dataValid)
  );

endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

  localparam int DEPTH = 16;
  localparam int WIDTH = 9;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0, wrN = 1'b1, rdN = 1'b1, rtN = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic dataValid, emptyN, fullN, halfN, overflow, underflow;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_strobe_fifo (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .dataIn(dataIn), .dataOut(dataOut), .dataValid(dataValid),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN),
    .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [WIDTH-1:0] pat(input int k);
    return WIDTH'((k * 41 + 3) % 512);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrN = 1'b1; rdN = 1'b1; rtN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic writeWord(input logic [WIDTH-1:0] d, output logic ovf);
    @(negedge clk);
    dataIn = d; wrN = 1'b0;
    @(negedge clk);
    ovf = overflow;
    wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readWord(output logic [WIDTH-1:0] d, output logic v,
                          output logic uf, output logic halfLow,
                          output logic halfAfter, output logic vAfter);
    @(negedge clk);
    rdN = 1'b0;
    @(negedge clk);
    d = dataOut; v = dataValid; uf = underflow; halfLow = halfN;
    rdN = 1'b1;
    @(negedge clk);
    halfAfter = halfN; vAfter = dataValid;
  endtask

  task automatic pulseRt();
    @(negedge clk); rtN = 1'b0;
    @(negedge clk); rtN = 1'b1;
    @(negedge clk);
  endtask

  // Scenario: flags in and after reset
  task automatic testReset();
    @(negedge clk);
    chk("R1 emptyN in reset", emptyN, 0);
    chk("R1 fullN in reset", fullN, 1);
    chk("R1 halfN in reset", halfN, 1);
    chk("R1 dataValid in reset", dataValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 empty after reset", emptyN, 0);
  endtask

  // Scenario: ordering, valid window
  task automatic testBasic();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    for (int k = 0; k < 3; k++) begin
      writeWord(pat(k), o);
      chk("R5 emptyN after write", emptyN, 1);
    end
    for (int k = 0; k < 3; k++) begin
      readWord(d, v, uf, hl, ha, va);
      chk("R2 order", d, pat(k));
      chk("R12 valid while low", v, 1);
      chk("R12 valid drops on rise", va, 0);
    end
    chk("R5 empty after drain", emptyN, 0);
  endtask

  // Scenario: read while empty
  task automatic testUnderflow();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    readWord(d, v, uf, hl, ha, va);
    chk("R4 underflow pulse", uf, 1);
    chk("R4 no valid", v, 0);
    @(negedge clk);
    chk("R4 pulse one cycle", underflow, 0);
    writeWord(9'h1AA, o);
    readWord(d, v, uf, hl, ha, va);
    chk("R4 pointer held", d, 9'h1AA);
  endtask

  // Scenario: strobes held low
  task automatic testHoldLow();
    logic v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    @(negedge clk);
    dataIn = 9'h0C3; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    readWord(d, v, uf, hl, ha, va);
    chk("R13 held write stores once", d, 9'h0C3);
    chk("R13 single entry", emptyN, 0);
  endtask

  // Scenario: fill, overflow, drain with half-full tracking
  task automatic testFill();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    doReset();
    for (int k = 0; k < DEPTH; k++) begin
      writeWord(pat(k), o);
      chk("R7 halfN on write", halfN, (k + 1 > HALF) ? 0 : 1);
      chk("R6 fullN on write", fullN, (k + 1 == DEPTH) ? 0 : 1);
    end
    writeWord(9'h1FF, o);
    chk("R3 overflow pulse", o, 1);
    chk("R3 still full", fullN, 0);
    chk("R3 pulse one cycle", overflow, 0);
    for (int k = 0; k < DEPTH; k++) begin
      readWord(d, v, uf, hl, ha, va);
      chk("R2 R3 drain order", d, pat(k));
      if (k == 0) chk("R6 full clears on read", fullN, 1);
      chk("R8 halfN during read low", hl, (DEPTH - k > HALF) ? 0 : 1);
      chk("R8 halfN after rise", ha, (DEPTH - 1 - k > HALF) ? 0 : 1);
    end
    chk("R3 overflow word absent", emptyN, 0);
    writeWord(pat(1), o);
    doReset();
    chk("R1 flags after reset empty", emptyN, 0);
    chk("R1 flags after reset half", halfN, 1);
  endtask

  // Scenario: retransmit replay and flag recompute
  task automatic testRetransmit();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    doReset();
    for (int k = 0; k < 5; k++) writeWord(pat(k), o);
    for (int k = 0; k < 3; k++) readWord(d, v, uf, hl, ha, va);
    pulseRt();
    readWord(d, v, uf, hl, ha, va);
    chk("R9 replay from start", d, pat(0));
    doReset();
    for (int k = 0; k < 10; k++) writeWord(pat(k), o);
    for (int k = 0; k < 4; k++) readWord(d, v, uf, hl, ha, va);
    chk("R8 below half before rewind", halfN, 1);
    pulseRt();
    chk("R9 half recomputed", halfN, 0);
    chk("R9 not empty", emptyN, 1);
    readWord(d, v, uf, hl, ha, va);
    chk("R9 rewound data", d, pat(0));
  endtask

  // Scenario: retransmit while read strobe low
  task automatic testRtIgnored();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    doReset();
    for (int k = 0; k < 4; k++) writeWord(pat(k), o);
    @(negedge clk); rdN = 1'b0;
    @(negedge clk); rtN = 1'b0;
    @(negedge clk); rtN = 1'b1;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk);
    readWord(d, v, uf, hl, ha, va);
    chk("R10 rewind ignored", d, pat(1));
  endtask

  // Scenario: reset release held off by a low strobe
  task automatic testResetHold();
    logic o, v, uf, hl, ha, va;
    logic [WIDTH-1:0] d;
    @(negedge clk);
    rstN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    dataIn = 9'h055; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    chk("R11 write ignored in held reset", emptyN, 0);
    rdN = 1'b1;
    repeat (2) @(negedge clk);
    writeWord(pat(7), o);
    chk("R11 released", emptyN, 1);
    readWord(d, v, uf, hl, ha, va);
    chk("R11 first word after release", d, pat(7));
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBasic();
    testUnderflow();
    testHoldLow();
    testFill();
    testRetransmit();
    testRtIgnored();
    testResetHold();
    finishRun();
  end

endmodule